// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a byte-wide asynchronous static RAM. The RAM has 19 address lines and three active-low strobes: chip select, output enable and write enable. On the user side, a request carries an address, a byte of write data and a direction flag. The request is taken when the controller reports it is not busy. Each read returns its byte on a one-cycle valid pulse.

On the memory side, the controller drives the address, the three strobes, an outbound data byte and the enable for the pad drivers. It samples the inbound data byte. The pad tristate buffers themselves sit outside the block.

All memory timing is converted to whole clock cycles by parameters. Each parameter is computed as the ceiling of a nanosecond limit divided by the clock period, so one netlist can serve other clock rates or speed grades. The controller keeps the following orderings:

- The address is stable before the write strobe falls.
- The write strobe stays high while the address changes.
- Its own data drivers are enabled only after the RAM has had time to release the bus.
- Chip select goes high for at least one cycle between any two accesses.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, all three memory strobes are high, `mem_dout_en` is 0, `busy` is 0 and `rd_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the access completes. Request inputs presented while `busy` is 1 have no effect on the memory pins or on the returned data.
- R3: A read (`req_write`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC = ceil(T_AA_NS/CLK_NS) cycles. With the defaults, RD_CYC is 6.
- R4: Read data is `mem_din` as sampled on the edge that ends the last read cycle. It appears on `rd_data` with `rd_valid`=1 for exactly one cycle, the cycle after the read strobes are released.
- R5: A write (`req_write`=1) first holds `mem_ce_n`=0 with `mem_we_n`=1 and `mem_oe_n`=1 for TA_CYC = ceil(T_HZ_NS/CLK_NS) cycles, which is 3 with the defaults. `mem_oe_n` stays 1 for the whole write.
- R6: During a write, `mem_we_n` is 0 for exactly WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS), ceil(T_AW_NS/CLK_NS)−TA_CYC) cycles, which is 3 with the defaults. `mem_dout_en` rises together with the fall of `mem_we_n` and falls one cycle after `mem_we_n` rises. `mem_dout` holds the request's byte throughout.
- R7: `mem_addr` holds the accepted address, and does not change, while `mem_ce_n` is 0.
- R8: `mem_ce_n` falls only on the edge that accepts a request, so it is high for at least one cycle between accesses.
- R9: `mem_oe_n` and `mem_we_n` are never both 0. `mem_dout_en` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Access in progress; requests are not taken |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DATA_W | Byte returned by the last read |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_dout_en | output | 1 | Enable for the data pad drivers |
| mem_din | input | DATA_W | Data from the memory |

## Verification
The checker watches the following on every cycle:

- Strobe exclusion and the bus-contention rule.
- Address and write-data stability while the chip is selected.
- The handshake between acceptance, `busy` and the fall of chip select.
- The single-cycle read-valid pulse.
- The driver enable outlasting the write strobe by one cycle.

The exact cycle counts of each phase are checked only by the bench. These are the read window, the setup window and the strobe width. The same holds for whether the captured byte is the one the memory presented at the end of the read window. The bench's memory model returns inverted data until the full access time has passed. Only the write-then-read scenarios can show that data reaches the intended address and returns unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_WSETUP  = 3'd2,
    ST_WSTROBE = 3'd3,
    ST_WHOLD   = 3'd4
  } sram_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_rst_sync.sv
module sram_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  // Load sets the remaining cycle count; otherwise count down to zero and hold.
  always_comb begin
    cnt_nx = cnt_q;
    if (load)              cnt_nx = load_val;
    else if (cnt_q != '0)  cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 6,
  parameter int TA_CYC = 3,
  parameter int WP_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             rd_capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dout_en,
  output logic             busy
);

  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);

  sram_state_e state_q, state_nx;

  // Next-state and timer control.
  always_comb begin
    state_nx   = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rd_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_nx = ST_WSETUP;
            tmr_val  = TA_LD;
          end else begin
            state_nx = ST_READ;
            tmr_val  = RD_LD;
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          state_nx   = ST_IDLE;
          rd_capture = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (tmr_done) begin
          state_nx = ST_WSTROBE;
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
        end
      end
      ST_WSTROBE: begin
        if (tmr_done) state_nx = ST_WHOLD;
      end
      ST_WHOLD: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  // Pins are registered from the next state so they leave the flops glitch-free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dout_en <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state_q <= state_nx;
      ce_n    <= (state_nx == ST_IDLE);
      oe_n    <= (state_nx != ST_READ);
      we_n    <= (state_nx != ST_WSTROBE);
      dout_en <= (state_nx == ST_WSTROBE) || (state_nx == ST_WHOLD);
      busy    <= (state_nx != ST_IDLE);
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 55,
  parameter int T_WP_NS = 30,
  parameter int T_DW_NS = 25,
  parameter int T_AW_NS = 55,
  parameter int T_HZ_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int RD_CYC  = max_int(1, ceil_div(T_AA_NS, CLK_NS));
  localparam int TA_CYC  = max_int(1, ceil_div(T_HZ_NS, CLK_NS));
  localparam int WP_RAW  = max_int(max_int(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_DW_NS, CLK_NS)),
                                   ceil_div(T_AW_NS, CLK_NS) - TA_CYC);
  localparam int WP_CYC  = max_int(1, WP_RAW);
  localparam int MAX_CYC = max_int(RD_CYC, max_int(TA_CYC, WP_CYC));
  localparam int CNT_W   = max_int(1, $clog2(MAX_CYC + 1));

  logic             rst_sync_n;
  logic             tmr_load, tmr_done, rd_capture, accept;
  logic [CNT_W-1:0] tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic             rvalid_q;

  sram_ctrl_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctrl_fsm #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC),
    .WP_CYC (WP_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .rd_capture (rd_capture),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dout_en    (mem_dout_en),
    .busy       (busy)
  );

  assign accept = req_valid && !busy;

  // Address and write data: captured once per access, held until the next accept.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Read capture on the edge that closes the counted access window.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rd_capture) begin
      rdata_q <= mem_din;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_q <= 1'b0;
    else             rvalid_q <= rd_capture;
  end

  assign mem_addr = addr_q;
  assign mem_dout = wdata_q;
  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dout_en
);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && !mem_oe_n));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |=> (!mem_dout_en || $stable(mem_dout)));

  // R6
  drv_outlast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dout_en);

  // R6
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dout_en);

  // R5
  strobe_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  // R8
  sel_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(req_valid && !busy));

  // R2
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R4
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .rd_valid    (rd_valid),
  .mem_addr    (mem_addr),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dout    (mem_dout),
  .mem_dout_en (mem_dout_en)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

  // Cycle counts worked out from the default nanosecond limits at a 10 ns design period.
  localparam int RD_CYC = 6;   // ceil(55/10)
  localparam int TA_CYC = 3;   // ceil(30/10)
  localparam int WP_CYC = 3;   // max(ceil(30/10), ceil(25/10), ceil(55/10)-3)

  typedef struct packed {
    logic        ce;
    logic        oe;
    logic        we;
    logic        den;
    logic        bsy;
    logic        rdv;
    logic [18:0] addr;
    logic [7:0]  d;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rd_valid;
  logic [7:0]  rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [7:0]  mem_dout;
  logic [7:0]  mem_din = 8'h00;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  exp_t       exp_q[$];
  logic [7:0] shadow [int];
  logic [7:0] model  [int];
  int         rd_cnt = 0, ce_lo_cnt = 0, we_lo_cnt = 0;
  logic       prev_we = 1'b1;

  always #2.5 clk = ~clk;

  sram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] peek(input logic [7:0] arr [int], input int a);
    return arr.exists(a) ? arr[a] : 8'h00;
  endfunction

  // Reference model and memory model, evaluated away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    e = '{ce:1'b1, oe:1'b1, we:1'b1, den:1'b0, bsy:1'b0, rdv:1'b0, addr:'0, d:'0};
    if (exp_q.size() > 0) e = exp_q.pop_front();
    chk("R8 ce_n", mem_ce_n, e.ce);
    chk("R3 oe_n", mem_oe_n, e.oe);
    chk("R6 we_n", mem_we_n, e.we);
    chk("R6 dout_en", mem_dout_en, e.den);
    chk("R2 busy", busy, e.bsy);
    chk("R4 rd_valid", rd_valid, e.rdv);
    if (e.rdv) chk("R4 rd_data", rd_data, e.d);
    if (!e.ce) chk("R7 addr", mem_addr, e.addr);
    if (e.den) chk("R6 dout", mem_dout, e.d);
    if (!mem_oe_n && !mem_we_n) chk("R9 strobes both low", 1, 0);
    if (mem_dout_en && !mem_oe_n) chk("R9 drive during read", 1, 0);

    // Memory model: strobe ordering and pulse widths counted in cycles.
    if (prev_we && !mem_we_n) chk("R5 setup cycles before strobe", ce_lo_cnt, TA_CYC);
    if (!prev_we && mem_we_n) begin
      chk("R6 strobe width", we_lo_cnt, WP_CYC);
      chk("R6 driver on at strobe rise", mem_dout_en, 1);
      model[int'(mem_addr)] = mem_dout;
    end
    if (!mem_ce_n && !mem_we_n) we_lo_cnt++; else we_lo_cnt = 0;
    if (!mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en) ce_lo_cnt++; else ce_lo_cnt = 0;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++; else rd_cnt = 0;
    prev_we = mem_we_n;
    mem_din = (rd_cnt >= RD_CYC) ? peek(model, int'(mem_addr)) : ~peek(model, int'(mem_addr));

    // Predict the access that begins at the coming edge.
    if (rst_n && req_valid && !busy) begin
      if (req_write) begin
        shadow[int'(req_addr)] = req_wdata;
        for (int i = 0; i < TA_CYC; i++)
          exp_q.push_back('{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, req_addr, req_wdata});
        for (int i = 0; i < WP_CYC; i++)
          exp_q.push_back('{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, req_addr, req_wdata});
        exp_q.push_back('{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, req_addr, req_wdata});
      end else begin
        for (int i = 0; i < RD_CYC; i++)
          exp_q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, req_addr, 8'h00});
        exp_q.push_back('{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'h0,
                          peek(shadow, int'(req_addr))});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // noise > 0 keeps presenting a different request while busy (R2: must be ignored).
  task automatic do_req(input bit w, input logic [18:0] a, input logic [7:0] d, input int noise);
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    for (int i = 0; i < noise; i++) begin
      req_addr = ~a; req_wdata = ~d; req_write = ~w;
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  logic [18:0] addrs [24];
  logic [7:0]  datas [24];

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(posedge clk);
    #1;
    // R1: idle pins while in reset
    chk("R1 ce_n in reset", mem_ce_n, 1);
    chk("R1 we_n in reset", mem_we_n, 1);
    chk("R1 oe_n in reset", mem_oe_n, 1);
    chk("R1 dout_en in reset", mem_dout_en, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk("R1 busy after reset", busy, 0);
    chk("R1 rd_valid after reset", rd_valid, 0);

    // Boundary addresses, back-to-back write then read (R5, R6, R3, R4).
    do_req(1'b1, 19'h00000, 8'hA5, 0);
    do_req(1'b1, 19'h7FFFF, 8'h3C, 0);
    do_req(1'b0, 19'h7FFFF, 8'h00, 0);
    do_req(1'b0, 19'h00000, 8'h00, 0);
    // Unwritten location reads zero (R4).
    do_req(1'b0, 19'h12345, 8'h00, 0);

    // Requests held while busy must be ignored (R2).
    do_req(1'b1, 19'h00ABC, 8'h5A, 3);
    do_req(1'b0, 19'h00ABC, 8'h00, 3);
    do_req(1'b0, 19'h7FF43, 8'h00, 0);

    // Random pattern: writes, then reads back in reverse order (R3, R4, R6, R7).
    for (int i = 0; i < 24; i++) begin
      addrs[i] = 19'($urandom);
      datas[i] = 8'($urandom);
      do_req(1'b1, addrs[i], datas[i], i % 3);
    end
    for (int i = 23; i >= 0; i--) do_req(1'b0, addrs[i], 8'h00, i % 2);

    // Interleaved write then immediate read of the same location.
    for (int i = 0; i < 10; i++) begin
      logic [18:0] a;
      logic [7:0]  d;
      a = 19'($urandom);
      d = 8'($urandom);
      do_req(1'b1, a, d, 0);
      do_req(1'b0, a, 8'h00, 0);
    end

    repeat (20) @(posedge clk);
    chk("R2 expected queue drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule